// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block receives message-signalled interrupts on behalf of a root port. It watches every inbound memory write presented on a snoop port and compares the write address with a 64-bit target address that software has programmed. A write that hits the target is absorbed instead of being passed on to memory. The low byte of its data is taken as a vector number, and the matching bit is set in a per-bank status register.

Vectors are grouped into banks of 32. Each bank has three registers: one that enables vectors, one that masks them, and one that holds status and is cleared by writing ones to it. One registered summary interrupt goes high whenever at least one status bit is both enabled and not masked. Software reaches the registers through a simple port with a write strobe, an address and write data. Read data is combinational and follows the address.

Top module: `msi_catcher`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The low word of the target address is read and written at offset 0x820 and the high word at 0x824.
- R3: Bank b has its registers at 0x828 + 12·b: vector enable at +0, vector mask at +4 and status at +8. Enable and mask read back what was written. With the default of two banks, the offsets are 0x828/0x82C/0x830 and 0x834/0x838/0x83C.
- R4: `snp_absorb` is high in the same cycle as `snp_valid` only when `snp_addr` equals {high word, low word} of the target. Otherwise it is low.
- R5: On an absorbed write, the vector v = `snp_data[7:0]` sets status bit v%32 of bank v/32 at the next clock edge. Data bits 31..8 have no effect.
- R6: An absorbed write whose vector is 64 or more (NUM_BANKS·32 or more) leaves every status register unchanged.
- R7: Writing to a status register clears each bit written as 1 and leaves each bit written as 0. A register write never sets a status bit.
- R8: When a write-1-to-clear and an absorbed vector hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is a register. After each edge it equals the OR, over all banks, of (status & enable & ~mask) as it stood before that edge.
- R10: A status bit whose enable bit is 0, or whose mask bit is 1, does not raise `irq_o`.
- R11: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| snp_valid | input | 1 | Inbound memory write present |
| snp_addr | input | 64 | Inbound write address |
| snp_data | input | 32 | Inbound write data |
| snp_absorb | output | 1 | Write hit the target and is consumed |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench targets the following corner cases:
- **Vectors 31, 32 and 63.** These sit at the edges of the two banks. A bank split made at the wrong place would set a bit in the wrong register.
- **Vectors 64 and 200, and data with junk above bit 7.** A decoder that wrapped these values or used too many data bits would set spurious status bits.
- **A write-1-to-clear in the same cycle as a matching capture.** A design that gave the clear priority would lose that interrupt.
- **A target that differs only in the high word.** A comparator that ignored the upper 32 bits would absorb this write.
- **Disabled and masked bits, then unmasking.** These checks show that the summary is gated correctly and arrives exactly one edge late.

// File: rtl/msi_catch_pkg.sv
package msi_catch_pkg;

    localparam int unsigned REG_AW      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned BANK_BITS   = 32;
    localparam int unsigned BANK_STRIDE = 12;

    localparam logic [REG_AW-1:0] OFS_TGT_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFS_TGT_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFS_BANK0  = 12'h828;

    typedef enum logic [1:0] {
        BREG_ENA  = 2'd0,
        BREG_MSK  = 2'd1,
        BREG_STS  = 2'd2,
        BREG_NONE = 2'd3
    } bank_reg_e;

endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode
    import msi_catch_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned VEC_W   = 8
) (
    input  logic               snp_valid,
    input  logic [63:0]        snp_addr,
    input  logic [DATA_W-1:0]  snp_data,
    input  logic [63:0]        target,
    output logic               hit,
    output logic [NUM_VEC-1:0] set_vec
);

    logic [VEC_W-1:0] vec;

    assign hit = snp_valid && (snp_addr == target);
    assign vec = snp_data[VEC_W-1:0];

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        assign set_vec[i] = hit && (vec == VEC_W'(i));
    end

endmodule

// File: rtl/msi_bank.sv
module msi_bank
    import msi_catch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  bank_reg_e            wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [BANK_BITS-1:0] set_bits,
    output logic [BANK_BITS-1:0] ena,
    output logic [BANK_BITS-1:0] msk,
    output logic [BANK_BITS-1:0] sts,
    output logic                 pend
);

    logic [BANK_BITS-1:0] clr_bits;
    logic [BANK_BITS-1:0] sts_n;

    assign clr_bits = (wr_en && wr_sel == BREG_STS) ? wr_data[BANK_BITS-1:0] : '0;
    assign sts_n    = (sts & ~clr_bits) | set_bits;
    assign pend     = |(sts & ena & ~msk);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= '0;
            msk <= '0;
            sts <= '0;
        end else begin
            if (wr_en && wr_sel == BREG_ENA) ena <= wr_data[BANK_BITS-1:0];
            if (wr_en && wr_sel == BREG_MSK) msk <= wr_data[BANK_BITS-1:0];
            sts <= sts_n;
        end
    end

    // R5 R8
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((sts & $past(set_bits)) == $past(set_bits)));

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~set_bits)) |=> ((sts & $past(clr_bits & ~set_bits)) == '0));

    // R3
    ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == BREG_ENA) |=> $stable(ena));

endmodule

// File: rtl/msi_catcher.sv
module msi_catcher
    import msi_catch_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned VEC_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        snp_valid,
    input  logic [63:0] snp_addr,
    input  logic [31:0] snp_data,
    output logic        snp_absorb,
    output logic        irq_o
);

    localparam int unsigned NUM_VEC = NUM_BANKS * BANK_BITS;

    logic [31:0]                          tgt_lo;
    logic [31:0]                          tgt_hi;
    logic [NUM_VEC-1:0]                   set_vec;
    logic [NUM_BANKS-1:0][BANK_BITS-1:0]  ena_a;
    logic [NUM_BANKS-1:0][BANK_BITS-1:0]  msk_a;
    logic [NUM_BANKS-1:0][BANK_BITS-1:0]  sts_a;
    logic [NUM_BANKS-1:0]                 pend_a;
    bank_reg_e                            bsel [NUM_BANKS];
    logic                                 any_pend;
    logic                                 irq_q;

    msi_vec_decode #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_dec (
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .target    ({tgt_hi, tgt_lo}),
        .hit       (snp_absorb),
        .set_vec   (set_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [REG_AW-1:0] BB = OFS_BANK0 + REG_AW'(BANK_STRIDE * b);

        assign bsel[b] = (reg_addr == BB)                 ? BREG_ENA :
                         (reg_addr == BB + REG_AW'(4))    ? BREG_MSK :
                         (reg_addr == BB + REG_AW'(8))    ? BREG_STS : BREG_NONE;

        msi_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wen),
            .wr_sel   (bsel[b]),
            .wr_data  (reg_wdata),
            .set_bits (set_vec[b*BANK_BITS +: BANK_BITS]),
            .ena      (ena_a[b]),
            .msk      (msk_a[b]),
            .sts      (sts_a[b]),
            .pend     (pend_a[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else if (reg_wen) begin
            if (reg_addr == OFS_TGT_LO) tgt_lo <= reg_wdata;
            if (reg_addr == OFS_TGT_HI) tgt_hi <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_TGT_LO) reg_rdata = tgt_lo;
        if (reg_addr == OFS_TGT_HI) reg_rdata = tgt_hi;
        for (int b = 0; b < NUM_BANKS; b++) begin
            unique case (bsel[b])
                BREG_ENA:  reg_rdata = ena_a[b];
                BREG_MSK:  reg_rdata = msk_a[b];
                BREG_STS:  reg_rdata = sts_a[b];
                BREG_NONE: ;
            endcase
        end
    end

    assign any_pend = |pend_a;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_pend;
    end

    assign irq_o = irq_q;

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> irq_o);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !irq_o);

    // R6
    no_wild_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_absorb && snp_data[VEC_W-1:0] >= VEC_W'(NUM_VEC)) |-> (set_vec == '0));

endmodule

// File: tb/msi_catcher_bench.sv
module msi_catcher_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wen;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        snp_valid;
    logic [63:0] snp_addr;
    logic [31:0] snp_data;
    logic        snp_absorb;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    bit [31:0] m_lo, m_hi;
    bit [31:0] m_en [2];
    bit [31:0] m_mk [2];
    bit [31:0] m_st [2];
    bit        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_catcher u_msi_catcher (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .snp_data(snp_data), .snp_absorb(snp_absorb),
        .irq_o(irq_o)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_read(input bit [11:0] a);
        if (a == 12'h820) return m_lo;
        if (a == 12'h824) return m_hi;
        for (int b = 0; b < 2; b++) begin
            if (a == 12'h828 + 12'(12*b)) return m_en[b];
            if (a == 12'h82C + 12'(12*b)) return m_mk[b];
            if (a == 12'h830 + 12'(12*b)) return m_st[b];
        end
        return 32'h0;
    endfunction

    function automatic bit exp_pend();
        bit p = 0;
        for (int b = 0; b < 2; b++) p |= |(m_st[b] & m_en[b] & ~m_mk[b]);
        return p;
    endfunction

    // one clock: drive at negedge, check comb outputs, update model, check irq
    task automatic step(input bit wen, input bit [11:0] a, input bit [31:0] wd,
                        input bit sv, input bit [63:0] sa, input bit [31:0] sd,
                        input string rtag, input string itag);
        bit ab, p;
        reg_wen = wen; reg_addr = a; reg_wdata = wd;
        snp_valid = sv; snp_addr = sa; snp_data = sd;
        #1;
        ab = sv && (sa == {m_hi, m_lo});
        chk(snp_absorb, ab, "R4");
        if (!wen) chk(reg_rdata, exp_read(a), rtag);
        p = exp_pend();
        @(posedge clk);
        if (wen) begin
            if (a == 12'h820) m_lo = wd;
            if (a == 12'h824) m_hi = wd;
            for (int b = 0; b < 2; b++) begin
                if (a == 12'h828 + 12'(12*b)) m_en[b] = wd;
                if (a == 12'h82C + 12'(12*b)) m_mk[b] = wd;
                if (a == 12'h830 + 12'(12*b)) m_st[b] &= ~wd;
            end
        end
        if (ab && sd[7:0] < 8'd64) m_st[sd[7:0] / 32] |= 32'h1 << (sd[7:0] % 32);
        m_irq = p;
        @(negedge clk);
        chk(irq_o, m_irq, itag);
    endtask

    task automatic rd(input bit [11:0] a, input string tag);
        step(0, a, 0, 0, 0, 0, tag, "R9");
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d, input string tag);
        step(1, a, d, 0, 0, 0, tag, "R9");
    endtask

    task automatic msi(input bit [63:0] sa, input bit [31:0] sd, input string tag);
        step(0, 12'h800, 0, 1, sa, sd, tag, "R9");
    endtask

    localparam bit [63:0] TGT = 64'h0000_0001_FEE0_1000;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit [11:0] alist [10];
        void'($urandom(32'h5EED_1234));
        alist = '{12'h820, 12'h824, 12'h828, 12'h82C, 12'h830,
                  12'h834, 12'h838, 12'h83C, 12'h840, 12'h81C};
        rst_n = 0; reg_wen = 0; reg_addr = 0; reg_wdata = 0;
        snp_valid = 0; snp_addr = 0; snp_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(irq_o, 0, "R1");
        foreach (alist[i]) rd(alist[i], "R1");

        wr(12'h820, TGT[31:0], "R2");
        wr(12'h824, TGT[63:32], "R2");
        rd(12'h820, "R2");
        rd(12'h824, "R2");
        wr(12'h828, 32'hFFFF_FFFF, "R3");
        wr(12'h834, 32'hFFFF_FFFF, "R3");
        wr(12'h82C, 32'h0000_0000, "R3");
        rd(12'h828, "R3");
        rd(12'h834, "R3");

        msi(TGT, 32'hABCD_1200, "R5");
        rd(12'h830, "R5");
        msi(TGT, 32'd31, "R5");
        msi(TGT, 32'd32, "R5");
        msi(TGT, 32'hFFFF_FF3F, "R5");
        rd(12'h830, "R5");
        rd(12'h83C, "R5");

        msi(TGT, 32'd64, "R6");
        msi(TGT, 32'd200, "R6");
        rd(12'h830, "R6");
        rd(12'h83C, "R6");
        msi(TGT ^ 64'h0000_0002_0000_0000, 32'd5, "R4");
        rd(12'h830, "R4");

        wr(12'h830, 32'h0000_0001, "R7");
        rd(12'h830, "R7");
        wr(12'h83C, 32'h0000_0000, "R7");
        rd(12'h83C, "R7");

        step(1, 12'h830, 32'h0000_0080, 1, TGT, 32'd7, "R8", "R9");
        rd(12'h830, "R8");
        wr(12'h830, 32'hFFFF_FFFF, "R7");
        wr(12'h828, 32'h0, "R10");
        wr(12'h834, 32'h0, "R10");
        rd(12'h83C, "R10");
        chk(irq_o, 0, "R10");
        wr(12'h834, 32'hFFFF_FFFF, "R10");
        wr(12'h838, 32'hFFFF_FFFF, "R10");
        rd(12'h838, "R10");
        chk(irq_o, 0, "R10");
        wr(12'h838, 32'h0, "R9");
        rd(12'h838, "R9");
        chk(irq_o, 1, "R9");

        wr(12'h840, 32'h1234_5678, "R11");
        rd(12'h840, "R11");
        rd(12'h81C, "R11");
        rd(12'h834, "R11");

        for (int n = 0; n < 600; n++) begin
            bit        w  = ($urandom_range(0, 9) < 4);
            bit [11:0] a  = alist[$urandom_range(0, 9)];
            bit [31:0] wd = $urandom;
            bit        sv = ($urandom_range(0, 3) != 0);
            bit [63:0] sa = ($urandom_range(0, 3) != 0) ? {m_hi, m_lo}
                            : ({m_hi, m_lo} ^ (64'h1 << $urandom_range(0, 63)));
            bit [31:0] sd = $urandom;
            if ($urandom_range(0, 9) < 8) sd[7:0] = 8'($urandom_range(0, 63));
            if (a == 12'h820 || a == 12'h824) w = w && ($urandom_range(0, 7) == 0);
            step(w, a, wd, sv, sa, sd, "R3", "R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule